// File: doc/BRIEF.md
# Watchdog Reset Pulse Generator

This block turns a single-cycle timeout trigger from a watchdog counter into a timed reset pulse. The pulse is timed in ticks of an external 1 µs enable. While the pulse lasts, the block drives a CPU reset line, which is active high. It also drives an external reset pin through a level and an output-enable, so that one pad model covers both push-pull and open-drain wiring. The pulse length is set by a width field. A field value of N gives a pulse of N+1 ticks. The width is captured when the pulse begins.

A single 32-bit configuration word sits at a parameterised offset on a simple register bus. A write always updates the width field. Pin polarity and drive style are protected: they change only when one of four key values appears in the top byte of the written word. They read back as two flag bits at the top of the word. The bus is a plain control port with no back-pressure. A write completes in the cycle where `bus_sel` and `bus_we` are both high. Read data is combinational while `bus_sel` is high and `bus_we` is low. The trigger and tick inputs are plain level inputs and have no handshake.

Top module: `rst_pulse_gen`

## Requirements
- R1: After reset the configuration word reads 0x000000FF: width 255, active low, open drain. No pulse is running, `cpu_rst` is 0, `ext_pin` is 1 and `ext_oe` is 0.
- R2: Every write to the configuration offset loads bits [WIDTH_BITS-1:0] of the data into the width field (default WIDTH_BITS = 20; the narrow variant uses 8). Bits between the width field and bit 29 always read 0.
- R3: A top byte of 0xA5 sets active-high polarity and a top byte of 0x5A sets active-low polarity. Bit 31 reads 1 when the polarity is active high.
- R4: A top byte of 0xA8 selects push-pull drive and a top byte of 0x8A selects open-drain drive. Bit 30 reads 1 when the drive is push-pull.
- R5: A top byte that is none of the four keys leaves polarity and drive unchanged, but the width is still written.
- R6: A trigger seen while idle starts a pulse in the next cycle. The pulse stays active through exactly width+1 clock edges on which `tick_1us` is high, and ends after the last of them.
- R7: A trigger that arrives during a pulse is ignored and does not extend or restart it. A width written during a pulse affects only later pulses.
- R8: In push-pull mode `ext_oe` is always 1, and `ext_pin` carries the active level during a pulse and the inactive level otherwise.
- R9: In open-drain mode `ext_oe` is 1 only while a pulse is active with active-low polarity. `ext_pin` is 0 whenever `ext_oe` is 1.
- R10: `cpu_rst` is high for exactly the same cycles as the external pulse. With active-high polarity, `ext_pin` equals `cpu_rst`.
- R11: Writes to any offset other than the configuration offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1us | input | 1 | Time-base enable, one cycle high per microsecond |
| trigger | input | 1 | Timeout event from the watchdog counter |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading the configuration offset |
| ext_pin | output | 1 | External reset pin level |
| ext_oe | output | 1 | External reset pin output-enable |
| cpu_rst | output | 1 | CPU reset, active high, same duration as the pin pulse |

## Verification
The bench measures pulse length in ticks, not cycles. It uses a width of zero, the reset default width of 255, and a tick that arrives only every third cycle. A design that loads N instead of N+1, or that counts clock cycles, would return the wrong tick count. A trigger and a width change are both applied in the middle of a pulse. A design that reloads its counter, or that reads the width live, would stretch the pulse or start a second one after it ends. A sequence of writes uses key, near-key and plain top bytes, including a write to a different offset. Any mix-up between the key values, or any update of the protected flags on a non-key write, would show in the read-back word. The pad outputs are sampled during and after pulses in each combination of polarity and drive. An open-drain output that drove a high level would be caught there.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;
  typedef enum logic {DRV_OD  = 1'b0, DRV_PP   = 1'b1} drv_e;

  typedef struct packed {
    pol_e pol;
    drv_e drv;
  } pad_cfg_t;

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
  import rpg_pkg::*;
#(
  parameter int          WIDTH_BITS = 20,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h18)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [WIDTH_BITS-1:0] width_o,
  output pad_cfg_t              pad_o
);

  localparam int PAD_ZEROS = 30 - WIDTH_BITS;
  localparam logic [WIDTH_BITS-1:0] WIDTH_RST = WIDTH_BITS'(8'hFF);

  logic       hit_wr;
  logic [7:0] key;

  assign hit_wr = bus_sel && bus_we && (bus_addr == REG_OFFSET);
  assign key    = bus_wdata[31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_o   <= WIDTH_RST;
      pad_o.pol <= POL_LOW;
      pad_o.drv <= DRV_OD;
    end else if (hit_wr) begin
      width_o <= bus_wdata[WIDTH_BITS-1:0];
      case (key)
        KEY_POL_HIGH: pad_o.pol <= POL_HIGH;
        KEY_POL_LOW:  pad_o.pol <= POL_LOW;
        KEY_DRV_PP:   pad_o.drv <= DRV_PP;
        KEY_DRV_OD:   pad_o.drv <= DRV_OD;
        default: ;
      endcase
    end
  end

  logic [31:0] word;
  generate
    if (PAD_ZEROS > 0) begin : g_padded
      assign word = {pad_o.pol, pad_o.drv, {PAD_ZEROS{1'b0}}, width_o};
    end else begin : g_full
      assign word = {pad_o.pol, pad_o.drv, width_o};
    end
  endgenerate

  assign bus_rdata = (bus_sel && !bus_we && bus_addr == REG_OFFSET) ? word : 32'h0;

endmodule

// File: rtl/rpg_pulse_timer.sv
module rpg_pulse_timer #(
  parameter int WIDTH_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  trigger,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  busy_o
);

  logic [WIDTH_BITS-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      remain <= '0;
    end else if (!busy_o) begin
      if (trigger) begin
        busy_o <= 1'b1;
        remain <= width_i;
      end
    end else if (tick) begin
      if (remain == '0) begin
        busy_o <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/rpg_pad_drive.sv
module rpg_pad_drive
  import rpg_pkg::*;
(
  input  logic     busy_i,
  input  pad_cfg_t pad_i,
  output logic     pin_o,
  output logic     oe_o
);

  always_comb begin
    pin_o = (pad_i.pol == POL_HIGH) ? busy_i : !busy_i;
    if (pad_i.drv == DRV_PP) begin
      oe_o = 1'b1;
    end else begin
      oe_o = busy_i && (pad_i.pol == POL_LOW);
    end
  end

endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rpg_pkg::*;
#(
  parameter int          WIDTH_BITS = 20,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h18)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              trigger,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ext_pin,
  output logic              ext_oe,
  output logic              cpu_rst
);

  logic [WIDTH_BITS-1:0] width;
  pad_cfg_t              pad_cfg;
  logic                  pulse_busy;

  rpg_cfg_reg #(
    .WIDTH_BITS (WIDTH_BITS),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .width_o   (width),
    .pad_o     (pad_cfg)
  );

  rpg_pulse_timer #(
    .WIDTH_BITS (WIDTH_BITS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1us),
    .trigger (trigger),
    .width_i (width),
    .busy_o  (pulse_busy)
  );

  rpg_pad_drive u_pad (
    .busy_i (pulse_busy),
    .pad_i  (pad_cfg),
    .pin_o  (ext_pin),
    .oe_o   (ext_oe)
  );

  assign cpu_rst = pulse_busy;

endmodule

// File: rtl/rst_pulse_gen_chk.sv
module rst_pulse_gen_chk
  import rpg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h18)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1us,
  input logic              trigger,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input pad_cfg_t          pad_cfg,
  input logic              ext_pin,
  input logic              ext_oe,
  input logic              cpu_rst
);

  logic wr_any, key_byte;
  assign wr_any   = bus_sel && bus_we;
  assign key_byte = (bus_wdata[31:24] == KEY_POL_HIGH) || (bus_wdata[31:24] == KEY_POL_LOW) ||
                    (bus_wdata[31:24] == KEY_DRV_PP)   || (bus_wdata[31:24] == KEY_DRV_OD);

  assert_flags_need_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == REG_OFFSET && !key_byte) |=> $stable(pad_cfg));

  assert_other_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr != REG_OFFSET) |=> $stable(pad_cfg));

  assert_start_from_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $past(trigger));

  assert_hold_until_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst && !tick_1us) |=> cpu_rst);

  assert_pp_always_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_cfg.drv == DRV_PP) |-> ext_oe);

  assert_od_low_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_cfg.drv == DRV_OD && ext_oe) |-> !ext_pin);

  assert_pin_tracks_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_cfg.pol == POL_HIGH) |-> (ext_pin == cpu_rst));

endmodule

bind rst_pulse_gen rst_pulse_gen_chk #(
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1us  (tick_1us),
  .trigger   (trigger),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_cfg   (pad_cfg),
  .ext_pin   (ext_pin),
  .ext_oe    (ext_oe),
  .cpu_rst   (cpu_rst)
);

// File: tb/rst_pulse_gen_test.sv
module rst_pulse_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigger = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        ext_pin, ext_oe, cpu_rst;
  logic        tick_1us;

  int checks = 0;
  int errors = 0;
  int tick_period = 1;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_1us = ((cyc % tick_period) == 0);

  rst_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .trigger(trigger),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_pin(ext_pin), .ext_oe(ext_oe), .cpu_rst(cpu_rst)
  );

  // {write data, expected read-back}, applied in order from the reset state
  localparam logic [63:0] VEC [10] = '{
    {32'h00000010, 32'h00000010},
    {32'hA5000020, 32'h80000020},
    {32'hA8000030, 32'hC0000030},
    {32'h12000040, 32'hC0000040},
    {32'h5A000050, 32'h40000050},
    {32'h8A000060, 32'h00000060},
    {32'hFFFFFFFF, 32'h000FFFFF},
    {32'hA5FFF003, 32'h800FF003},
    {32'h8A000000, 32'h80000000},
    {32'h5A000000, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Launches a pulse and counts tick edges while it is active.
  // poke >= 0: at that pulse cycle, re-trigger and write poke_data.
  task automatic pulse(input int poke, input logic [31:0] poke_data,
                       output int n, output logic fp, output logic fo, output logic fc,
                       output logic ip, output logic io, output logic again);
    int k;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    n = 0; k = 0;
    fp = ext_pin; fo = ext_oe; fc = cpu_rst;
    while (cpu_rst && k < 5000) begin
      if (k == poke) begin
        trigger = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = OFS; bus_wdata = poke_data;
      end
      if (tick_1us) n++;
      @(negedge clk);
      trigger = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
      k++;
    end
    ip = ext_pin; io = ext_oe; again = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (cpu_rst) again = 1'b1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int n;
    logic fp, fo, fc, ip, io, again;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(OFS, r);
    check("R1 reset word", r, 32'h000000FF);
    check("R1 cpu_rst idle", {31'b0, cpu_rst}, 32'h0);
    check("R1 pin idle", {31'b0, ext_pin}, 32'h1);
    check("R1 oe idle", {31'b0, ext_oe}, 32'h0);

    // R6 default width 255 -> 256 ticks; R9 open-drain active-low pad
    pulse(-1, 32'h0, n, fp, fo, fc, ip, io, again);
    check("R6 default width ticks", n, 256);
    check("R9 od active-low pin during", {31'b0, fp}, 32'h0);
    check("R9 od active-low oe during", {31'b0, fo}, 32'h1);
    check("R9 od oe after", {31'b0, io}, 32'h0);
    check("R10 cpu_rst during", {31'b0, fc}, 32'h1);

    // R2 R3 R4 R5 keyed write table
    for (int i = 0; i < 10; i++) begin
      wr(OFS, VEC[i][63:32]);
      rd(OFS, r);
      check($sformatf("R2-R5 vector %0d (R3 R4 R5)", i), r, VEC[i][31:0]);
    end

    // R6 width 0 -> one tick
    pulse(-1, 32'h0, n, fp, fo, fc, ip, io, again);
    check("R6 width zero ticks", n, 1);

    // R6 sparse ticks: width 2, tick every third cycle
    wr(OFS, 32'h8A000002);
    tick_period = 3;
    pulse(-1, 32'h0, n, fp, fo, fc, ip, io, again);
    check("R6 sparse tick count", n, 3);
    tick_period = 1;

    // R7 retrigger ignored, width sampled at start
    wr(OFS, 32'h00000005);
    pulse(2, 32'hAB00001F, n, fp, fo, fc, ip, io, again);
    check("R7 retrigger length", n, 6);
    check("R7 no restart", {31'b0, again}, 32'h0);
    pulse(-1, 32'h0, n, fp, fo, fc, ip, io, again);
    check("R7 new width next pulse", n, 32);

    // R8 R10 push-pull active high
    wr(OFS, 32'hA5000001);
    wr(OFS, 32'hA8000001);
    pulse(-1, 32'h0, n, fp, fo, fc, ip, io, again);
    check("R8 pp ticks", n, 2);
    check("R8 pp pin during", {31'b0, fp}, 32'h1);
    check("R8 pp oe during", {31'b0, fo}, 32'h1);
    check("R8 pp pin after", {31'b0, ip}, 32'h0);
    check("R8 pp oe after", {31'b0, io}, 32'h1);
    check("R10 pin equals cpu_rst", {31'b0, fp}, {31'b0, fc});

    // R9 open-drain active high never drives
    wr(OFS, 32'h8A000001);
    pulse(-1, 32'h0, n, fp, fo, fc, ip, io, again);
    check("R9 od active-high oe during", {31'b0, fo}, 32'h0);
    check("R9 od active-high oe after", {31'b0, io}, 32'h0);

    // R11 other offset ignored
    wr(8'h1C, 32'h5A000077);
    rd(OFS, r);
    check("R11 other offset", r, 32'h80000001);

    finish_run();
  end

endmodule